// File: doc/BRIEF.md
# Fault Collection Controller with Key-Protected Modes

This block gathers fault indications from surrounding logic, remembers each one in a sticky status bit, and applies a per-fault reaction chosen by software: a one-cycle reset request, a level interrupt, or a level error-out signal. A small register bus carries key, control, status, fault-enable and reaction-select registers. Bit `EXT_IDX` of the fault vector is also driven by `ext_err_in`, so an external interrupt pin can report that another device has failed.

Two state machines set the behaviour. The mode machine has two states, NORMAL and CONFIG. Its transitions are ENTER_CFG (unlock, control key, then operation code 1) and LEAVE_CFG (control key, then operation code 2). The supervision machine has two states, WD_IDLE and WD_RUN. Its transitions are ARM (an unreacted fault fires while supervision is active), CANCEL (a configured reaction fires, or the mode leaves NORMAL) and EXPIRE (the timeout runs out and a reset request is pulsed). Reactions and supervision run only in NORMAL.

Register map (byte addresses): 0x00 control, 0x04 control key, 0x08 unlock, 0x0C clear key, 0x10+4w status word w, 0x20+4w enable word w, 0x40+4k reaction word k. Fault i sits in bit i%32 of word i/32. Its 2-bit reaction field sits at bits 2*(i%16)+1:2*(i%16) of reaction word i/16. Reaction codes are 0 none, 1 reset, 2 interrupt, 3 error-out. Control reads return operation status in bits 1:0 (0 idle, 2 failed, 3 done), the CONFIG flag in bit 4 and the unlock flag in bit 5.

Top module: `fault_collector`

## Requirements
- R1: After reset: mode is NORMAL; the control register reads 0; only fault `EXT_IDX` (32) is enabled; every reaction field is 0; all status bits are 0; `rst_req`, `irq_out` and `err_out` are low.
- R2: Writing 0xBC to bits 7:0 of the unlock register, then 0x913756AF to the control key, then operation code 1 to control bits 1:0, moves NORMAL to CONFIG. Operation status then reads 3.
- R3: A control key is valid only for the write that immediately follows it. A control write that lacks the matching key, or (for code 1) lacks the unlock, leaves the mode unchanged and sets operation status to 2.
- R4: In CONFIG, key 0x825A132B followed by operation code 2 returns the block to NORMAL with status 3 and clears the unlock flag.
- R5: Enable and reaction registers accept writes only in CONFIG. Writes to them in NORMAL have no effect.
- R6: An enabled fault input that is high at a clock edge sets its status bit. A disabled fault neither latches nor has any effect.
- R7: A status bit is cleared by writing 1 to it in the write directly after the clear key 0xAB12CD34. Without that key, the write leaves the status unchanged.
- R8: Reaction 1 produces a one-cycle `rst_req` in the cycle after the edge that latches the fault.
- R9: `irq_out` is high while any enabled, latched fault has reaction 2. `err_out` is high while any has reaction 3.
- R10: When any enabled fault has a nonzero reaction, an enabled fault with reaction 0 starts the supervision timer. `rst_req` then pulses for one cycle, `WDG_CYCLES` edges after the latching edge.
- R11: A configured reaction that fires while the timer runs cancels it, and no reset follows.
- R12: When no enabled fault has a nonzero reaction, an unreacted fault never leads to a reset.
- R13: `ext_err_in` acts as fault 32, so with its default enable it can start the supervision timer.
- R14: In CONFIG, faults still latch, but `rst_req`, `irq_out` and `err_out` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fault_in | input | NUM_FAULTS | Fault indications, active high |
| ext_err_in | input | 1 | External error pin, ORed into fault `EXT_IDX` |
| rst_req | output | 1 | One-cycle reset request |
| irq_out | output | 1 | Interrupt level |
| err_out | output | 1 | Error-out level |

## Verification
The mode machine is driven by a table of key and control writes: the correct order, missing keys, a key broken by an intervening write, the wrong key for the current mode, and a control write without the unlock. These patterns separate the one-shot key rule from plain key matching. Fault tests then exercise each reaction code, with reset pulses sampled in the exact cycle they appear. An unreacted fault is tried with supervision active and inactive, and with a configured reaction arriving mid-count, which separates expiry from cancellation. The external pin, disabled faults and CONFIG-mode faults show where faults latch but must not react.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic { MODE_NORMAL, MODE_CONFIG } mode_e;
    typedef enum logic [1:0] { KEY_NONE, KEY_TO_CFG, KEY_TO_NRM } key_e;
    typedef enum logic { WD_IDLE, WD_RUN } wd_e;

    localparam logic [7:0]  LOCK_KEY  = 8'hBC;
    localparam logic [31:0] CFG_KEY   = 32'h9137_56AF;
    localparam logic [31:0] NRM_KEY   = 32'h825A_132B;
    localparam logic [31:0] CLR_KEY   = 32'hAB12_CD34;

    localparam logic [1:0]  OP_TO_CFG = 2'd1;
    localparam logic [1:0]  OP_TO_NRM = 2'd2;

    localparam logic [1:0]  OPS_IDLE  = 2'd0;
    localparam logic [1:0]  OPS_FAIL  = 2'd2;
    localparam logic [1:0]  OPS_DONE  = 2'd3;

    localparam logic [1:0]  RX_NONE   = 2'd0;
    localparam logic [1:0]  RX_RESET  = 2'd1;
    localparam logic [1:0]  RX_IRQ    = 2'd2;
    localparam logic [1:0]  RX_EOUT   = 2'd3;

    localparam logic [7:0]  A_CTRL    = 8'h00;
    localparam logic [7:0]  A_CKEY    = 8'h04;
    localparam logic [7:0]  A_LOCK    = 8'h08;
    localparam logic [7:0]  A_CLRKEY  = 8'h0C;
    localparam logic [7:0]  A_ST      = 8'h10;
    localparam logic [7:0]  A_EN      = 8'h20;
    localparam logic [7:0]  A_RX      = 8'h40;

endpackage

// File: rtl/fcc_keys.sv
module fcc_keys
    import fcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_wr,
    input  logic        wr_lock,
    input  logic        wr_ckey,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    output mode_e       mode,
    output logic        unlocked,
    output logic [1:0]  opstat
);

    key_e       armed, nxt_key;
    mode_e      nxt_mode;
    logic       nxt_unlk;
    logic [1:0] nxt_ops;

    always_comb begin
        nxt_mode = mode;
        nxt_unlk = unlocked;
        nxt_ops  = opstat;
        nxt_key  = any_wr ? KEY_NONE : armed;
        if (wr_ckey) begin
            if (wdata == CFG_KEY)      nxt_key = KEY_TO_CFG;
            else if (wdata == NRM_KEY) nxt_key = KEY_TO_NRM;
        end
        if (wr_lock && wdata[7:0] == LOCK_KEY) nxt_unlk = 1'b1;
        if (wr_ctrl) begin
            nxt_ops = OPS_FAIL;
            unique case (mode)
                MODE_NORMAL: begin
                    if (wdata[1:0] == OP_TO_CFG && armed == KEY_TO_CFG && unlocked) begin
                        nxt_mode = MODE_CONFIG;
                        nxt_ops  = OPS_DONE;
                    end
                end
                MODE_CONFIG: begin
                    if (wdata[1:0] == OP_TO_NRM && armed == KEY_TO_NRM) begin
                        nxt_mode = MODE_NORMAL;
                        nxt_ops  = OPS_DONE;
                        nxt_unlk = 1'b0;
                    end
                end
                default: nxt_mode = MODE_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_NORMAL;
            armed    <= KEY_NONE;
            unlocked <= 1'b0;
            opstat   <= OPS_IDLE;
        end else begin
            mode     <= nxt_mode;
            armed    <= nxt_key;
            unlocked <= nxt_unlk;
            opstat   <= nxt_ops;
        end
    end

    // R2: CONFIG is only reached through an unlocked, keyed code-1 write
    a_r2_cfg_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CONFIG && $past(mode) == MODE_NORMAL)
            |-> $past(wr_ctrl && armed == KEY_TO_CFG && unlocked));

    // R3: every control write reports done or failed
    a_r3_ctrl_reports: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (opstat == OPS_DONE || opstat == OPS_FAIL));

    // R4: returning to NORMAL closes the unlock
    a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && $past(mode) == MODE_CONFIG) |-> !unlocked);

endmodule

// File: rtl/fcc_fault_bank.sv
module fcc_fault_bank
    import fcc_pkg::*;
#(
    parameter int NF      = 40,
    parameter int EXT_IDX = 32,
    parameter int NW      = (NF + 31) / 32,
    parameter int NR      = (NF + 15) / 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  mode_e            mode,
    input  logic [NF-1:0]    faults,
    output logic [NW*32-1:0] en_words,
    output logic [NW*32-1:0] st_words,
    output logic [NR*32-1:0] rx_words,
    output logic             rst_fire,
    output logic             irq_lvl,
    output logic             eout_lvl,
    output logic             sup_active,
    output logic             wd_start,
    output logic             wd_stop
);

    logic          clr_armed;
    logic          in_normal;
    logic [NF-1:0] en_v, st_v, hit_rst, irq_v, eout_v, new_norx, new_rx, armed_v;

    assign in_normal = (mode == MODE_NORMAL);

    always_ff @(posedge clk) begin
        if (!rst_n)      clr_armed <= 1'b0;
        else if (bus_we) clr_armed <= (bus_addr == A_CLRKEY && bus_wdata == CLR_KEY);
    end

    for (genvar gi = 0; gi < NF; gi++) begin : g_flt
        localparam logic [7:0] AS = A_ST + 8'(4 * (gi / 32));
        localparam logic [7:0] AE = A_EN + 8'(4 * (gi / 32));
        localparam logic [7:0] AR = A_RX + 8'(4 * (gi / 16));
        localparam int         BI = gi % 32;
        localparam int         RB = 2 * (gi % 16);
        logic       en_q, st_q, new_evt;
        logic [1:0] rx_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= (gi == EXT_IDX);
                rx_q <= RX_NONE;
                st_q <= 1'b0;
            end else begin
                if (mode == MODE_CONFIG && bus_we && bus_addr == AE) en_q <= bus_wdata[BI];
                if (mode == MODE_CONFIG && bus_we && bus_addr == AR) rx_q <= bus_wdata[RB +: 2];
                if (faults[gi] && en_q)
                    st_q <= 1'b1;
                else if (clr_armed && bus_we && bus_addr == AS && bus_wdata[BI])
                    st_q <= 1'b0;
            end
        end

        assign new_evt      = faults[gi] & en_q & ~st_q;
        assign en_v[gi]     = en_q;
        assign st_v[gi]     = st_q;
        assign hit_rst[gi]  = new_evt & (rx_q == RX_RESET);
        assign irq_v[gi]    = st_q & en_q & (rx_q == RX_IRQ);
        assign eout_v[gi]   = st_q & en_q & (rx_q == RX_EOUT);
        assign new_norx[gi] = new_evt & (rx_q == RX_NONE);
        assign new_rx[gi]   = new_evt & (rx_q != RX_NONE);
        assign armed_v[gi]  = en_q & (rx_q != RX_NONE);
        assign rx_words[2*gi +: 2] = rx_q;
    end

    assign en_words[NF-1:0] = en_v;
    assign st_words[NF-1:0] = st_v;
    for (genvar gp = NF; gp < NW * 32; gp++) begin : g_pad
        assign en_words[gp] = 1'b0;
        assign st_words[gp] = 1'b0;
    end
    for (genvar gr = 2 * NF; gr < NR * 32; gr++) begin : g_rpad
        assign rx_words[gr] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rst_fire <= 1'b0;
        else        rst_fire <= in_normal && (|hit_rst);
    end

    assign irq_lvl    = in_normal && (|irq_v);
    assign eout_lvl   = in_normal && (|eout_v);
    assign sup_active = |armed_v;
    assign wd_start   = |new_norx;
    assign wd_stop    = |new_rx;

    // R6: a fault that was disabled and clear cannot become latched
    a_r6_disabled_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_v & ~$past(st_v) & ~$past(en_v)) == '0));

    // R5: enables move only after a cycle spent in CONFIG
    a_r5_en_cfg_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_CONFIG) |=> $stable(en_v));

    // R7: no status bit falls unless the clear key was just written
    a_r7_clear_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_armed) |=> ((~st_v & $past(st_v)) == '0));

endmodule

// File: rtl/fcc_supervisor.sv
module fcc_supervisor
    import fcc_pkg::*;
#(
    parameter int WDG_CYCLES = 256,
    parameter int CW         = $clog2(WDG_CYCLES + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  sup_active,
    input  logic  wd_start,
    input  logic  wd_stop,
    output logic  wd_pulse
);

    localparam logic [CW-1:0] LAST = CW'(WDG_CYCLES - 1);

    wd_e           st, nxt;
    logic [CW-1:0] cnt;
    logic          in_normal;

    assign in_normal = (mode == MODE_NORMAL);

    always_comb begin
        nxt = st;
        unique case (st)
            WD_IDLE: if (in_normal && sup_active && wd_start && !wd_stop) nxt = WD_RUN;
            WD_RUN:  if (!in_normal || wd_stop || cnt == LAST)            nxt = WD_IDLE;
            default: nxt = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= WD_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= (st == WD_RUN && nxt == WD_RUN) ? cnt + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wd_pulse <= 1'b0;
        else        wd_pulse <= (st == WD_RUN) && in_normal && !wd_stop && (cnt == LAST);
    end

    // R10: the count never passes the timeout
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN) |-> (cnt <= LAST));

    // R10: expiry yields a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pulse |=> !wd_pulse);

    // R11: a reaction during the count cancels it without a pulse
    a_r11_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN && wd_stop) |=> (st == WD_IDLE && !wd_pulse));

endmodule

// File: rtl/fault_collector.sv
module fault_collector
    import fcc_pkg::*;
#(
    parameter int NUM_FAULTS = 40,
    parameter int EXT_IDX    = 32,
    parameter int WDG_CYCLES = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_FAULTS-1:0] fault_in,
    input  logic                  ext_err_in,
    output logic                  rst_req,
    output logic                  irq_out,
    output logic                  err_out
);

    localparam int NW = (NUM_FAULTS + 31) / 32;
    localparam int NR = (NUM_FAULTS + 15) / 16;

    mode_e                  mode;
    logic                   unlocked, rst_fire, wd_pulse;
    logic                   sup_active, wd_start, wd_stop;
    logic [1:0]             opstat;
    logic [NUM_FAULTS-1:0]  fvec;
    logic [NW*32-1:0]       en_words, st_words;
    logic [NR*32-1:0]       rx_words;

    always_comb begin
        fvec          = fault_in;
        fvec[EXT_IDX] = fault_in[EXT_IDX] | ext_err_in;
    end

    fcc_keys u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_wr   (bus_we),
        .wr_lock  (bus_we && bus_addr == A_LOCK),
        .wr_ckey  (bus_we && bus_addr == A_CKEY),
        .wr_ctrl  (bus_we && bus_addr == A_CTRL),
        .wdata    (bus_wdata),
        .mode     (mode),
        .unlocked (unlocked),
        .opstat   (opstat)
    );

    fcc_fault_bank #(.NF(NUM_FAULTS), .EXT_IDX(EXT_IDX), .NW(NW), .NR(NR)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .mode       (mode),
        .faults     (fvec),
        .en_words   (en_words),
        .st_words   (st_words),
        .rx_words   (rx_words),
        .rst_fire   (rst_fire),
        .irq_lvl    (irq_out),
        .eout_lvl   (err_out),
        .sup_active (sup_active),
        .wd_start   (wd_start),
        .wd_stop    (wd_stop)
    );

    fcc_supervisor #(.WDG_CYCLES(WDG_CYCLES)) u_sup (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sup_active (sup_active),
        .wd_start   (wd_start),
        .wd_stop    (wd_stop),
        .wd_pulse   (wd_pulse)
    );

    assign rst_req = rst_fire | wd_pulse;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)
            bus_rdata = {26'd0, unlocked, mode == MODE_CONFIG, 2'b00, opstat};
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == A_ST + 8'(4 * w)) bus_rdata = st_words[32*w +: 32];
            if (bus_addr == A_EN + 8'(4 * w)) bus_rdata = en_words[32*w +: 32];
        end
        for (int k = 0; k < NR; k++) begin
            if (bus_addr == A_RX + 8'(4 * k)) bus_rdata = rx_words[32*k +: 32];
        end
    end

    // R14: outputs stay quiet while in CONFIG
    a_r14_quiet_in_config: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CONFIG) |-> (!irq_out && !err_out && !rst_fire));

endmodule

// File: tb/tb_fault_collector.sv
`timescale 1ns/1ps
module tb_fault_collector;

    localparam int NF = 40;
    localparam int W  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NF-1:0] fault_in = '0;
    logic        ext_err_in = 1'b0;
    logic        rst_req, irq_out, err_out;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fault_collector #(.NUM_FAULTS(NF), .EXT_IDX(32), .WDG_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in),
        .ext_err_in(ext_err_in), .rst_req(rst_req), .irq_out(irq_out), .err_out(err_out)
    );

    // {addr, wdata, expected control read, requirement}
    localparam logic [79:0] TBL [0:12] = '{
        {8'h00, 32'h0000_0001, 32'h0000_0002, 8'd3},  // R3 no key, no unlock
        {8'h08, 32'h0000_00BC, 32'h0000_0022, 8'd2},  // R2 unlock
        {8'h04, 32'h9137_56AF, 32'h0000_0022, 8'd2},
        {8'h08, 32'h0000_00BC, 32'h0000_0022, 8'd3},  // R3 intervening write voids key
        {8'h00, 32'h0000_0001, 32'h0000_0022, 8'd3},
        {8'h04, 32'h9137_56AF, 32'h0000_0022, 8'd2},
        {8'h00, 32'h0000_0001, 32'h0000_0033, 8'd2},  // R2 enters CONFIG
        {8'h04, 32'h9137_56AF, 32'h0000_0033, 8'd3},  // R3 wrong key for mode
        {8'h00, 32'h0000_0002, 32'h0000_0032, 8'd3},
        {8'h04, 32'h825A_132B, 32'h0000_0032, 8'd4},
        {8'h00, 32'h0000_0002, 32'h0000_0003, 8'd4},  // R4 back to NORMAL, relocked
        {8'h04, 32'h9137_56AF, 32'h0000_0003, 8'd3},
        {8'h00, 32'h0000_0001, 32'h0000_0002, 8'd3}   // R3 locked again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic enter_cfg();
        wr(8'h08, 32'hBC); wr(8'h04, 32'h9137_56AF); wr(8'h00, 32'h1);
    endtask

    task automatic leave_cfg();
        wr(8'h04, 32'h825A_132B); wr(8'h00, 32'h2);
    endtask

    task automatic clr(input logic [7:0] a, input logic [31:0] m);
        wr(8'h0C, 32'hAB12_CD34); wr(a, m);
    endtask

    task automatic watch(input int n, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
    endtask

    task automatic expect_wd_reset(input string req);
        @(negedge clk);
        check({req, " no reset at latch"}, {31'd0, rst_req}, 32'd0);
        repeat (W - 1) @(negedge clk);
        check({req, " no reset before timeout"}, {31'd0, rst_req}, 32'd0);
        @(negedge clk);
        check({req, " reset at timeout"}, {31'd0, rst_req}, 32'd1);
        @(negedge clk);
        check({req, " reset one cycle"}, {31'd0, rst_req}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); check("R1 control", d, 32'h0);
        rd(8'h20, d); check("R1 enable word0", d, 32'h0);
        rd(8'h24, d); check("R1 enable word1 (fault 32)", d, 32'h1);
        rd(8'h40, d); check("R1 reaction word0", d, 32'h0);
        rd(8'h10, d); check("R1 status word0", d, 32'h0);
        check("R1 outputs", {29'd0, rst_req, irq_out, err_out}, 32'h0);

        // R2 R3 R4 key and control sequence table
        for (int i = 0; i < 13; i++) begin
            wr(TBL[i][79:72], TBL[i][71:40]);
            rd(8'h00, d);
            check($sformatf("R%0d table row %0d", TBL[i][7:0], i), d, TBL[i][39:8]);
        end

        // R5 writes in NORMAL ignored
        wr(8'h20, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h20, d); check("R5 enable write in NORMAL", d, 32'h0);
        rd(8'h40, d); check("R5 reaction write in NORMAL", d, 32'h0);

        enter_cfg();
        wr(8'h20, 32'h0000_000F);
        wr(8'h40, 32'h0000_0039);   // f0 reset, f1 irq, f2 error-out, f3 none
        rd(8'h20, d); check("R5 enable write in CONFIG", d, 32'hF);
        rd(8'h40, d); check("R5 reaction write in CONFIG", d, 32'h39);

        // R14 faults latch in CONFIG without reaction
        fault_in[0] = 1'b1; fault_in[1] = 1'b1;
        @(negedge clk);
        rd(8'h10, d); check("R14 status latches in CONFIG", d, 32'h3);
        check("R14 outputs quiet", {29'd0, rst_req, irq_out, err_out}, 32'h0);
        fault_in[0] = 1'b0; fault_in[1] = 1'b0;
        clr(8'h10, 32'h3);
        leave_cfg();
        rd(8'h00, d); check("R4 back in NORMAL", d, 32'h3);

        // R8 reset reaction
        fault_in[0] = 1'b1;
        @(negedge clk);
        check("R8 reset pulse", {31'd0, rst_req}, 32'd1);
        @(negedge clk);
        check("R8 reset one cycle", {31'd0, rst_req}, 32'd0);
        fault_in[0] = 1'b0;

        // R7 clear needs key
        wr(8'h10, 32'h1);
        rd(8'h10, d); check("R7 clear without key", d, 32'h1);
        clr(8'h10, 32'h1);
        rd(8'h10, d); check("R7 clear with key", d, 32'h0);

        // R9 interrupt and error-out levels
        fault_in[1] = 1'b1;
        @(negedge clk);
        check("R9 irq level", {30'd0, irq_out, err_out}, 32'h2);
        fault_in[1] = 1'b0;
        clr(8'h10, 32'h2);
        check("R9 irq drops on clear", {31'd0, irq_out}, 32'd0);
        fault_in[2] = 1'b1;
        @(negedge clk);
        check("R9 error-out level", {30'd0, irq_out, err_out}, 32'h1);
        fault_in[2] = 1'b0;
        clr(8'h10, 32'h4);
        check("R9 error-out drops", {31'd0, err_out}, 32'd0);

        // R10 unreacted fault under active supervision
        fault_in[3] = 1'b1;
        expect_wd_reset("R10");
        fault_in[3] = 1'b0;
        clr(8'h10, 32'h8);

        // R11 reaction cancels supervision
        fault_in[3] = 1'b1;
        repeat (5) @(negedge clk);
        fault_in[1] = 1'b1;
        watch(W + 4, seen);
        check("R11 no reset after cancel", {31'd0, seen}, 32'd0);
        check("R11 irq from cancelling fault", {31'd0, irq_out}, 32'd1);
        fault_in[3] = 1'b0; fault_in[1] = 1'b0;
        clr(8'h10, 32'hA);

        // R6 disabled fault has no effect
        fault_in[5] = 1'b1;
        watch(W + 4, seen);
        rd(8'h10, d); check("R6 disabled fault not latched", d, 32'h0);
        check("R6 disabled fault no reset", {31'd0, seen}, 32'd0);
        fault_in[5] = 1'b0;

        // R13 external pin as fault 32
        ext_err_in = 1'b1;
        expect_wd_reset("R13");
        rd(8'h14, d); check("R13 fault 32 latched", d, 32'h1);
        ext_err_in = 1'b0;
        clr(8'h14, 32'h1);

        // R12 supervision inactive
        enter_cfg();
        wr(8'h40, 32'h0);
        leave_cfg();
        fault_in[3] = 1'b1; ext_err_in = 1'b1;
        watch(W + 4, seen);
        check("R12 no reset when inactive", {31'd0, seen}, 32'd0);
        fault_in[3] = 1'b0; ext_err_in = 1'b0;
        clr(8'h10, 32'h8); clr(8'h14, 32'h1);

        // R6 disabling fault 32 blocks the external pin
        enter_cfg();
        wr(8'h24, 32'h0);
        leave_cfg();
        ext_err_in = 1'b1;
        @(negedge clk);
        rd(8'h14, d); check("R6 fault 32 disabled", d, 32'h0);
        ext_err_in = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule